// File: doc/BRIEF.md
# Quadlet Receive Queue with Status Word

This block buffers 32-bit quadlets that arrive from a link-side producer until a host takes them out through a data read port. Every stored quadlet carries one extra tag bit that marks the first quadlet of a packet. When the host pops a quadlet, the tag of that quadlet is shown in a 32-bit status word. The host can therefore find packet boundaries without a separate side channel.

The status word reports the fill state of the queue and the current occupancy. It also holds a write-one flush control that clears itself. A synchronous chip reset and a separate bus-reset input both return the queue and the status word to their defaults. The status word uses big-endian bit numbering: status bit 0 is vector bit 31, and status bit k is vector bit 31-k. The requirements below give both positions.

Top module: `rxq_top`

## Requirements
- R1: After `rst` the status word reads 0x10000000 (only the empty flag set) and `rd_data` reads 0.
- R2: The full flag (status bit 0, vector bit 31) is 1 exactly while occupancy equals DEPTH. A push that arrives while the flag is 1 is dropped.
- R3: The almost-full flag (status bit 1, vector bit 30) is 1 exactly while occupancy equals DEPTH-1.
- R4: The almost-empty flag (status bit 2, vector bit 29) is 1 exactly while occupancy equals 1.
- R5: The empty flag (status bit 3, vector bit 28) is 1 exactly while occupancy equals 0.
- R6: Status bits 7..15 (vector bits 24:16, most significant bit at vector bit 24) hold the occupancy as an unsigned 9-bit number. It is updated at the same edge that accepts a push or a pop.
- R7: Quadlets leave in the order they were accepted. A `rd_en` pulse at edge k makes the popped quadlet appear on `rd_data` after edge k, and it is held there until the next read.
- R8: Status bit 16 (vector bit 15) is 1 when the last quadlet read had its `push_sop` tag set. It is 0 after a read of an untagged quadlet and after an empty read.
- R9: A status write with vector bit 12 (status bit 19) set makes that bit read 1 for one cycle. At the following edge the queue is emptied, the bit returns to 0, `rd_data` and the packet-start bit go to 0, and any push or read in that cycle is ignored.
- R10: A `bus_rst` pulse empties the queue, clears the flush bit and the packet-start bit, and returns the status word to 0x10000000.
- R11: A read while the queue is empty returns 0 on `rd_data` and leaves the occupancy unchanged.
- R12: A push and a read in the same cycle, with the queue neither full nor empty, leave the occupancy unchanged.
- R13: Reserved status bits (vector bits 27:25, 14:13 and 11:0) always read 0. Status writes have no effect other than the flush in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| bus_rst | input | 1 | Synchronous bus-reset event, restores defaults |
| push_valid | input | 1 | Offer one quadlet to the queue this cycle |
| push_data | input | 32 | Quadlet to store |
| push_sop | input | 1 | Quadlet is the first of a packet |
| rd_en | input | 1 | Host read of the data register (one pop) |
| rd_data | output | 32 | Last quadlet read, 0 after an empty read |
| st_wr_en | input | 1 | Host write strobe for the status word |
| st_wr_data | input | 32 | Status write data, only vector bit 12 acts |
| status | output | 32 | Status word |

## Verification
The bench builds the block with DEPTH=8. With that depth, full, almost-full, almost-empty and every occupancy value in between are reached within a handful of cycles and are visited thousands of times. A long pseudo-random sweep, with phases weighted toward filling, draining and balance, compares the status word and `rd_data` every cycle against an arithmetic queue model. It also mixes in flush writes, writes to reserved bits and bus resets. Directed steps cover pushes into a full queue, push plus read at the full and empty edges, and reads past empty.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned STAT_W     = 32;
  localparam int unsigned CNT_FLD_W  = 9;

  // Vector positions inside the status word (status bit k == vector bit 31-k)
  localparam int unsigned B_FULL     = 31;
  localparam int unsigned B_AFULL    = 30;
  localparam int unsigned B_AEMPTY   = 29;
  localparam int unsigned B_EMPTY    = 28;
  localparam int unsigned B_CNT_LO   = 16;
  localparam int unsigned B_SOP      = 15;
  localparam int unsigned B_FLUSH    = 12;

  localparam logic [STAT_W-1:0] RSV_MASK = 32'h0E00_6FFF;

  typedef struct packed {
    logic full;
    logic afull;
    logic aempty;
    logic empty;
  } rxq_flags_t;

  localparam rxq_flags_t FLAGS_IDLE = '{full: 1'b0, afull: 1'b0, aempty: 1'b0, empty: 1'b1};

  function automatic logic [STAT_W-1:0] pack_status(
      input rxq_flags_t           f,
      input logic [CNT_FLD_W-1:0] cnt,
      input logic                 sop,
      input logic                 flush);
    logic [STAT_W-1:0] s;
    s                              = '0;
    s[B_FULL]                      = f.full;
    s[B_AFULL]                     = f.afull;
    s[B_AEMPTY]                    = f.aempty;
    s[B_EMPTY]                     = f.empty;
    s[B_CNT_LO +: CNT_FLD_W]       = cnt;
    s[B_SOP]                       = sop;
    s[B_FLUSH]                     = flush;
    return s;
  endfunction

endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int unsigned W     = 33,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8,
  parameter int unsigned CW    = 9
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          we,
  output logic          re,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count,
  output rxq_flags_t    flags,
  output logic          pop_ok
);

  localparam logic [CW-1:0] CNT_FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_AFULL = CW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_ONE   = CW'(1);
  localparam logic [AW-1:0] PTR_LAST  = AW'(DEPTH - 1);
  localparam bit            POW2      = (DEPTH & (DEPTH - 1)) == 0;

  logic [AW-1:0] wp_q, rp_q, wp_nxt, rp_nxt;
  logic [CW-1:0] cnt_nxt;
  rxq_flags_t    flags_nxt;
  logic          acc_push, acc_pop;

  assign acc_push = push_req & ~flags.full  & ~clr;
  assign acc_pop  = pop_req  & ~flags.empty & ~clr;

  generate
    if (POW2) begin : g_wrap_free
      assign wp_nxt = wp_q + AW'(1);
      assign rp_nxt = rp_q + AW'(1);
    end else begin : g_wrap_cmp
      assign wp_nxt = (wp_q == PTR_LAST) ? '0 : wp_q + AW'(1);
      assign rp_nxt = (rp_q == PTR_LAST) ? '0 : rp_q + AW'(1);
    end
  endgenerate

  always_comb begin
    unique case ({acc_push, acc_pop})
      2'b10:   cnt_nxt = count + CW'(1);
      2'b01:   cnt_nxt = count - CW'(1);
      default: cnt_nxt = count;
    endcase
    flags_nxt.full   = (cnt_nxt == CNT_FULL);
    flags_nxt.afull  = (cnt_nxt == CNT_AFULL);
    flags_nxt.aempty = (cnt_nxt == CNT_ONE);
    flags_nxt.empty  = (cnt_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
      flags <= FLAGS_IDLE;
    end else begin
      if (acc_push) wp_q <= wp_nxt;
      if (acc_pop)  rp_q <= rp_nxt;
      count <= cnt_nxt;
      flags <= flags_nxt;
    end
  end

  assign we     = acc_push;
  assign re     = acc_pop;
  assign waddr  = wp_q;
  assign raddr  = rp_q;
  assign pop_ok = acc_pop;

endmodule

// File: rtl/rxq_csr.sv
module rxq_csr
  import rxq_pkg::*;
#(
  parameter int unsigned CW = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              flush_wr,
  input  logic              rd_en,
  input  logic              pop_ok,
  input  logic              tag_q,
  input  logic [CW-1:0]     count,
  input  rxq_flags_t        flags,
  output logic              flush_q,
  output logic              hold_ok,
  output logic [STAT_W-1:0] status
);

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      flush_q <= 1'b0;
      hold_ok <= 1'b0;
    end else begin
      flush_q <= flush_wr;
      if (flush_q)    hold_ok <= 1'b0;
      else if (rd_en) hold_ok <= pop_ok;
    end
  end

  assign status = pack_status(flags, CNT_FLD_W'(count), hold_ok & tag_q, flush_q);

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_sop,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              st_wr_en,
  input  logic [31:0]       st_wr_data,
  output logic [31:0]       status
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned EW = DATA_W + 1;

  logic          clr, flush_q, hold_ok;
  logic          we, re, pop_ok;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;
  rxq_flags_t    flags;
  logic [EW-1:0] mem_q;
  logic          flush_wr;
  wire           unused_wr_bits = ^{st_wr_data[31:B_FLUSH+1], st_wr_data[B_FLUSH-1:0]};

  assign clr      = rst | bus_rst | flush_q;
  assign flush_wr = st_wr_en & st_wr_data[B_FLUSH];

  rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk      (clk),
    .clr      (clr),
    .push_req (push_valid),
    .pop_req  (rd_en),
    .we       (we),
    .re       (re),
    .waddr    (waddr),
    .raddr    (raddr),
    .count    (count),
    .flags    (flags),
    .pop_ok   (pop_ok)
  );

  rxq_mem #(.W(EW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata ({push_sop, push_data}),
    .re    (re),
    .raddr (raddr),
    .rdata (mem_q)
  );

  rxq_csr #(.CW(CW)) u_csr (
    .clk      (clk),
    .rst      (rst),
    .bus_rst  (bus_rst),
    .flush_wr (flush_wr),
    .rd_en    (rd_en),
    .pop_ok   (pop_ok),
    .tag_q    (mem_q[DATA_W]),
    .count    (count),
    .flags    (flags),
    .flush_q  (flush_q),
    .hold_ok  (hold_ok),
    .status   (status)
  );

  assign rd_data = hold_ok ? mem_q[DATA_W-1:0] : '0;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rst,
  input logic              push_valid,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [31:0]       status
);

  localparam logic [8:0] C_FULL  = 9'(DEPTH);
  localparam logic [8:0] C_AFULL = 9'(DEPTH - 1);

  logic [8:0] cnt;
  assign cnt = status[B_CNT_LO +: 9];

  p_full_r2: assert property (@(posedge clk) disable iff (rst)
    status[B_FULL] == (cnt == C_FULL));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (status[B_FULL] && push_valid && !rd_en && !status[B_FLUSH]) |=> $stable(cnt));

  p_afull_r3: assert property (@(posedge clk) disable iff (rst)
    status[B_AFULL] == (cnt == C_AFULL));

  p_aempty_r4: assert property (@(posedge clk) disable iff (rst)
    status[B_AEMPTY] == (cnt == 9'd1));

  p_empty_r5: assert property (@(posedge clk) disable iff (rst)
    status[B_EMPTY] == (cnt == 9'd0));

  p_flush_done_r9: assert property (@(posedge clk) disable iff (rst || bus_rst)
    $rose(status[B_FLUSH]) |=> (cnt == 9'd0 && status[B_EMPTY] && rd_data == '0));

  p_bus_reset_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> status == 32'h1000_0000);

  p_empty_read_r11: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (status[B_EMPTY] && rd_en && !push_valid && !status[B_FLUSH]) |=> (rd_data == '0 && $stable(cnt)));

  p_balanced_r12: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (!status[B_FULL] && !status[B_EMPTY] && push_valid && rd_en && !status[B_FLUSH]) |=> $stable(cnt));

  p_reserved_r13: assert property (@(posedge clk) disable iff (rst)
    (status & RSV_MASK) == '0);

endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rst    (bus_rst),
  .push_valid (push_valid),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .status     (status)
);

// File: tb/sim_rxq_top.sv
`timescale 1ns/1ps
module sim_rxq_top;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst, bus_rst, push_valid, push_sop, rd_en, st_wr_en;
  logic [31:0] push_data, st_wr_data, rd_data, status;

  always #2.5 clk = ~clk;

  rxq_top #(.DEPTH(DEPTH), .DATA_W(32)) u0 (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .push_valid(push_valid),
    .push_data(push_data), .push_sop(push_sop), .rd_en(rd_en), .rd_data(rd_data),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .status(status)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  logic [32:0] q[$];
  logic [31:0] m_rd   = '0;
  logic        m_sop  = 1'b0;
  logic        m_fl   = 1'b0;

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    int n = q.size();
    s[31]    = (n == DEPTH);
    s[30]    = (n == DEPTH - 1);
    s[29]    = (n == 1);
    s[28]    = (n == 0);
    s[24:16] = 9'(n);
    s[15]    = m_sop;
    s[12]    = m_fl;
    return s;
  endfunction

  function automatic string field_req(input logic [31:0] d);
    if (d[31])        return "R2";
    if (d[30])        return "R3";
    if (d[29])        return "R4";
    if (d[28])        return "R5";
    if (|d[24:16])    return "R6";
    if (d[15])        return "R8";
    if (d[12])        return "R9";
    return "R13";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] es = exp_status();
    check(status === es, field_req(status ^ es), status, es);
    check(rd_data === m_rd, "R7", rd_data, m_rd);
  endtask

  task automatic model_edge(input logic p, s, input logic [31:0] d, input logic r, w,
                            input logic [31:0] wd, input logic b);
    if (b) begin
      q.delete(); m_rd = '0; m_sop = 0; m_fl = 0;
    end else if (m_fl) begin
      q.delete(); m_rd = '0; m_sop = 0;
      m_fl = w & wd[12];
    end else begin
      int n = q.size();
      if (r) begin
        if (n > 0) begin
          m_rd = q[0][31:0]; m_sop = q[0][32]; void'(q.pop_front());
        end else begin
          m_rd = '0; m_sop = 0;
        end
      end
      if (p && n < DEPTH) q.push_back({s, d});
      m_fl = w & wd[12];
    end
  endtask

  task automatic step(input logic p, s, input logic [31:0] d, input logic r, w,
                      input logic [31:0] wd, input logic b);
    push_valid = p; push_sop = s; push_data = d; rd_en = r;
    st_wr_en = w; st_wr_data = wd; bus_rst = b;
    @(posedge clk);
    model_edge(p, s, d, r, w, wd, b);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    rst = 1; bus_rst = 0; push_valid = 0; push_sop = 0; push_data = '0;
    rd_en = 0; st_wr_en = 0; st_wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check(status === 32'h1000_0000, "R1", status, 32'h1000_0000);
    check(rd_data === 32'h0, "R1", rd_data, 32'h0);

    // Fill past capacity: R2 drop, R3/R4/R6 every level
    for (int i = 0; i < DEPTH + 3; i++)
      step(1, (i % 3) == 0, 32'hA000_0000 + i, 0, 0, '0, 0);
    check(status[24:16] === 9'(DEPTH) && status[31], "R2", status, exp_status());

    // Reserved bits written: no effect (R13)
    step(0, 0, '0, 0, 1, 32'hFFFF_EFFF, 0);
    check(status === 32'h8008_0000, "R13", status, 32'h8008_0000);

    // Push + read while full: push dropped (R2), then balanced at DEPTH-1 (R12)
    step(1, 0, 32'hBEEF_0001, 1, 0, '0, 0);
    check(status[24:16] === 9'(DEPTH - 1), "R2", {23'b0, status[24:16]}, DEPTH - 1);
    step(1, 1, 32'hBEEF_0002, 1, 0, '0, 0);
    check(status[24:16] === 9'(DEPTH - 1), "R12", {23'b0, status[24:16]}, DEPTH - 1);

    // Drain past empty (R7, R8, R11)
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, '0, 1, 0, '0, 0);
    check(rd_data === 32'h0 && status === 32'h1000_0000, "R11", rd_data, 32'h0);

    // Empty push + read: read returns 0, push lands
    step(1, 1, 32'hC0DE_0001, 1, 0, '0, 0);
    check(rd_data === 32'h0 && status[24:16] === 9'd1, "R11", rd_data, 32'h0);

    // Flush (R9)
    step(1, 0, 32'hC0DE_0002, 0, 0, '0, 0);
    step(0, 0, '0, 1, 0, '0, 0);
    step(1, 0, 32'hC0DE_0003, 0, 1, 32'h0000_1000, 0);
    check(status[12] === 1'b1, "R9", status, exp_status());
    step(1, 1, 32'hC0DE_0004, 1, 0, '0, 0);
    check(status === 32'h1000_0000 && rd_data === 0, "R9", status, 32'h1000_0000);

    // Bus reset (R10)
    step(1, 1, 32'hD000_0001, 0, 0, '0, 0);
    step(1, 0, 32'hD000_0002, 0, 0, '0, 0);
    step(0, 0, '0, 1, 0, '0, 0);
    step(1, 0, 32'hD000_0003, 0, 1, 32'h0000_1000, 1);
    check(status === 32'h1000_0000 && rd_data === 0, "R10", status, 32'h1000_0000);

    // Pseudo-random sweep in weighted phases
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] pth;
      logic p, r, w, b;
      logic [31:0] wd;
      seed = seed * 32'd1664525 + 32'd1013904223;
      case ((i / 400) % 3)
        0:       pth = 8'd192;
        1:       pth = 8'd64;
        default: pth = 8'd128;
      endcase
      p  = seed[7:0] < pth;
      r  = seed[15:8] >= pth;
      w  = seed[21:16] == 6'd0;
      wd = seed[22] ? {seed[31:13], 1'b1, seed[11:0]} : {seed[31:13], 1'b0, seed[11:0]};
      b  = seed[31:23] == 9'd0;
      step(p, seed[5], {seed[15:0], seed[31:16]}, r, w, wd, b);
    end

    push_valid = 0; rd_en = 0; st_wr_en = 0; bus_rst = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule